// File: doc/BRIEF.md
# Software Write-Protection Sequence Guard

This block sits between the source of qualified byte writes and the page write controller of a byte-programmable nonvolatile array. It watches each write (17-bit address, 8-bit data) for two fixed command sequences. A three-write sequence arms protection, or opens a single load session while protection is on. A six-write sequence removes protection. Command writes are consumed here and never reach the page buffer. A protection change takes effect at the end of the next programming period, even when no data bytes follow the command.

While protection is on, a write that is not preceded by the three-write sequence is not forwarded. The block instead requests a dummy cycle, so the controller runs a full programming time without changing any data. The protection flag is held in a register that the normal reset leaves alone. Only a test initialisation input or the six-write sequence clears it.

Writes arrive on a valid/ready stream and leave on a second valid/ready stream. The block holds no buffer. A forwarded write is presented on the output in the same cycle, and the input `in_ready` follows `out_ready`, so back-pressure passes straight through. Command writes and blocked writes are accepted at once whatever `out_ready` is. The sequence detector advances only on an accepted write. The load-window close and programming-done strobes are plain pulses from the controller.

Top module: `wp_guard`

## Requirements
- R1: After `tst_init` and reset, `prot_on` is 0 and neither `out_valid` nor `dummy_req` is asserted. An unprotected ordinary write is forwarded with its address and data unchanged.
- R2: The enable sequence is data 0xAA at address 0x05555, then 0x55 at 0x02AAA, then 0xA0 at 0x05555. All three writes are accepted and not forwarded. When protection was off, `prot_on` becomes 1 on the `prog_done` pulse that follows.
- R3: While `prot_on` is 1 and no session is unlocked, an ordinary write is accepted (`in_ready`=1), is not forwarded, and raises `dummy_req` in its cycle.
- R4: Under protection, completing the three-write sequence unlocks the session. Ordinary writes are then forwarded until `load_close`, and are blocked again after it.
- R5: The disable sequence is 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then 0x20@0x05555. It is consumed, ordinary writes in the same session are forwarded, and `prot_on` becomes 0 on the next `prog_done`.
- R6: A write that does not match the expected next step returns the detector to idle and is handled as an ordinary write: forwarded when unprotected, blocked when locked. An unmatched 0xAA@0x05555 is taken as a fresh first step.
- R7: Asserting `rst_n` low leaves `prot_on` unchanged. A `tst_init` pulse clears it.
- R8: A write to be forwarded is accepted only when `out_ready` is 1. A write that is offered but not accepted does not move the detector. Command writes are accepted even when `out_ready` is 0.
- R9: The final write of either completed sequence raises `dummy_req`, so that a programming period follows even with no data.
- R10: `prot_on` changes only on a `prog_done` or `tst_init` pulse. `load_close` does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the detector and session state; protection is kept |
| tst_init | input | 1 | Test-only initialisation, clears protection |
| in_valid | input | 1 | Incoming write valid |
| in_ready | output | 1 | Incoming write accepted |
| in_addr | input | 17 | Write address |
| in_data | input | 8 | Write data |
| out_valid | output | 1 | Forwarded write to page buffer (write permit) |
| out_ready | input | 1 | Page buffer can take a byte |
| out_addr | output | 17 | Forwarded address |
| out_data | output | 8 | Forwarded data |
| load_close | input | 1 | Load window closed pulse; ends the session |
| prog_done | input | 1 | Programming period finished pulse |
| prot_on | output | 1 | Protection active |
| dummy_req | output | 1 | Start the programming timer without data |

## Verification
A detector left in the wrong step shows up at the next command write. Either a command byte is forwarded as data on `out_valid`, or the completing write fails to raise `dummy_req`. Both are visible in that write's own cycle. A wrong session flag shows on the first ordinary write under protection, as forwarding where blocking was expected or the reverse. A wrong pending flag becomes visible only one cycle after the following `prog_done`, as a wrong `prot_on`. For that reason every table row that pulses `prog_done` checks `prot_on`.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_G1,
    SQ_G2,
    SQ_G3,
    SQ_G4,
    SQ_G5
  } sq_e;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_guard_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter logic [AW-1:0] LO_ADDR = 17'h05555,
  parameter logic [AW-1:0] HI_ADDR = 17'h02AAA,
  parameter logic [DW-1:0] K_FIRST = 8'hAA,
  parameter logic [DW-1:0] K_SECOND = 8'h55,
  parameter logic [DW-1:0] K_UNLOCK = 8'hA0,
  parameter logic [DW-1:0] K_ERASE = 8'h80,
  parameter logic [DW-1:0] K_DISABLE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          is_cmd,
  output logic          unlock_hit,
  output logic          disable_hit
);
  sq_e st_q, st_d;
  logic lo_first, hi_second, lo_unl, lo_era, lo_dis, stepped;

  assign lo_first  = (addr == LO_ADDR) && (data == K_FIRST);
  assign hi_second = (addr == HI_ADDR) && (data == K_SECOND);
  assign lo_unl    = (addr == LO_ADDR) && (data == K_UNLOCK);
  assign lo_era    = (addr == LO_ADDR) && (data == K_ERASE);
  assign lo_dis    = (addr == LO_ADDR) && (data == K_DISABLE);

  always_comb begin
    st_d        = SQ_IDLE;
    stepped     = 1'b0;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    case (st_q)
      SQ_G1: if (hi_second) begin st_d = SQ_G2; stepped = 1'b1; end
      SQ_G2: begin
        if (lo_unl) begin
          st_d = SQ_IDLE; stepped = 1'b1; unlock_hit = 1'b1;
        end else if (lo_era) begin
          st_d = SQ_G3; stepped = 1'b1;
        end
      end
      SQ_G3: if (lo_first) begin st_d = SQ_G4; stepped = 1'b1; end
      SQ_G4: if (hi_second) begin st_d = SQ_G5; stepped = 1'b1; end
      SQ_G5: if (lo_dis) begin
        st_d = SQ_IDLE; stepped = 1'b1; disable_hit = 1'b1;
      end
      default: ;
    endcase
    // unmatched write: restart on a first step, otherwise fall back to idle
    if (!stepped && lo_first) begin
      st_d    = SQ_G1;
      stepped = 1'b1;
    end
    is_cmd = stepped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else if (acc) st_q <= st_d;
  end

  p_idle_after_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (unlock_hit || disable_hit)) |=> (st_q == SQ_IDLE));
  p_hold_without_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(st_q));
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic tst_init,
  input  logic acc,
  input  logic unlock_hit,
  input  logic disable_hit,
  input  logic load_close,
  input  logic prog_done,
  output logic prot_on,
  output logic sess_open
);
  logic prot_q, pend_en_q, pend_dis_q, sess_q;

  // protection flag: deliberately outside the normal reset
  always_ff @(posedge clk) begin
    if (tst_init) prot_q <= 1'b0;
    else if (prog_done && pend_dis_q) prot_q <= 1'b0;
    else if (prog_done && pend_en_q) prot_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tst_init) begin
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
    end else begin
      if (prog_done) begin
        pend_en_q  <= 1'b0;
        pend_dis_q <= 1'b0;
      end
      if (acc && unlock_hit && !prot_q) pend_en_q <= 1'b1;
      if (acc && disable_hit) begin
        pend_dis_q <= 1'b1;
        pend_en_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sess_q <= 1'b0;
    else if (acc && (unlock_hit || disable_hit)) sess_q <= 1'b1;
    else if (load_close) sess_q <= 1'b0;
  end

  assign prot_on   = prot_q;
  assign sess_open = sess_q;

  p_prot_moves_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q != $past(prot_q)) |-> $past(prog_done || tst_init));
  p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n || tst_init)
    (pend_dis_q && prog_done) |=> !prot_q);
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tst_init,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          load_close,
  input  logic          prog_done,
  output logic          prot_on,
  output logic          dummy_req
);
  logic seq_cmd, unl_hit, dis_hit, sess_open, blocked, acc;

  wp_seq_match #(.AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n), .acc(acc), .addr(in_addr), .data(in_data),
    .is_cmd(seq_cmd), .unlock_hit(unl_hit), .disable_hit(dis_hit)
  );

  wp_prot_state u_state (
    .clk(clk), .rst_n(rst_n), .tst_init(tst_init), .acc(acc),
    .unlock_hit(unl_hit), .disable_hit(dis_hit), .load_close(load_close),
    .prog_done(prog_done), .prot_on(prot_on), .sess_open(sess_open)
  );

  // commands and blocked writes are absorbed here; data waits on the sink
  assign blocked   = !seq_cmd && prot_on && !sess_open;
  assign in_ready  = (seq_cmd || blocked) ? 1'b1 : out_ready;
  assign acc       = in_valid && in_ready;
  assign out_valid = in_valid && !seq_cmd && !blocked;
  assign out_addr  = in_addr;
  assign out_data  = in_data;
  assign dummy_req = acc && (blocked || (seq_cmd && (unl_hit || dis_hit)));

  p_cmd_never_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seq_cmd);
  p_locked_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(prot_on && !sess_open));
  p_dummy_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_req |-> (in_valid && in_ready && !out_valid));
endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;
  logic clk = 1'b0;
  logic rst_n, tst_init, in_valid, in_ready, out_valid, out_ready;
  logic [16:0] in_addr, out_addr;
  logic [7:0] in_data, out_data;
  logic load_close, prog_done, prot_on, dummy_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n), .tst_init(tst_init), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .load_close(load_close), .prog_done(prog_done),
    .prot_on(prot_on), .dummy_req(dummy_req)
  );

  typedef struct packed {
    logic [1:0] k;   // 0 write, 1 load_close, 2 prog_done
    logic [16:0] a;
    logic [7:0] d;
    logic eo; logic ed; logic ep;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{0, 17'h00010, 8'h11, 1, 0, 0, 1},   // R1 plain write forwarded
    '{0, 17'h05555, 8'hAA, 0, 0, 0, 2},   // R2 enable
    '{0, 17'h02AAA, 8'h55, 0, 0, 0, 2},
    '{0, 17'h05555, 8'hA0, 0, 1, 0, 9},   // R9
    '{0, 17'h00020, 8'h33, 1, 0, 0, 2},
    '{1, 17'h0, 8'h0, 0, 0, 0, 10},       // R10 load_close keeps state
    '{2, 17'h0, 8'h0, 0, 0, 1, 2},        // R2 takes effect
    '{0, 17'h00030, 8'h44, 0, 1, 1, 3},   // R3 blocked
    '{1, 17'h0, 8'h0, 0, 0, 1, 10},
    '{2, 17'h0, 8'h0, 0, 0, 1, 10},
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 4},   // R4 unlock
    '{0, 17'h02AAA, 8'h55, 0, 0, 1, 4},
    '{0, 17'h05555, 8'hA0, 0, 1, 1, 9},
    '{0, 17'h00040, 8'h55, 1, 0, 1, 4},
    '{1, 17'h0, 8'h0, 0, 0, 1, 4},
    '{0, 17'h00041, 8'h66, 0, 1, 1, 4},
    '{2, 17'h0, 8'h0, 0, 0, 1, 10},
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 6},   // R6 mismatch while locked
    '{0, 17'h01234, 8'h77, 0, 1, 1, 6},
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 6},   // R6 restart
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 6},
    '{0, 17'h02AAA, 8'h55, 0, 0, 1, 6},
    '{0, 17'h05555, 8'hA0, 0, 1, 1, 6},
    '{0, 17'h00050, 8'h88, 1, 0, 1, 6},
    '{1, 17'h0, 8'h0, 0, 0, 1, 5},
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 5},   // R5 disable
    '{0, 17'h02AAA, 8'h55, 0, 0, 1, 5},
    '{0, 17'h05555, 8'h80, 0, 0, 1, 5},
    '{0, 17'h05555, 8'hAA, 0, 0, 1, 5},
    '{0, 17'h02AAA, 8'h55, 0, 0, 1, 5},
    '{0, 17'h05555, 8'h20, 0, 1, 1, 9},
    '{0, 17'h00060, 8'h99, 1, 0, 1, 5},
    '{1, 17'h0, 8'h0, 0, 0, 1, 10},
    '{2, 17'h0, 8'h0, 0, 0, 0, 5},
    '{0, 17'h05555, 8'hAA, 0, 0, 0, 6},   // R6 mismatch unprotected
    '{0, 17'h02AAA, 8'h56, 1, 0, 0, 6}
  };

  task automatic chk(input logic act, input logic exp, input int rq, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] k, input logic [16:0] a, input logic [7:0] d,
                      input logic eo, input logic ed, input logic er, input logic ep,
                      input int rq);
    @(negedge clk);
    in_valid   = (k == 2'd0);
    in_addr    = a;
    in_data    = d;
    load_close = (k == 2'd1);
    prog_done  = (k == 2'd2);
    #1;
    chk(out_valid, eo, rq, "out_valid");
    chk(dummy_req, ed, rq, "dummy_req");
    if (k == 2'd0) chk(in_ready, er, rq, "in_ready");
    if (eo) begin
      checks++;
      if (out_addr !== a || out_data !== d) begin
        failures++;
        $display("FAIL R%0d out addr/data actual=%h/%h expected=%h/%h",
                 rq, out_addr, out_data, a, d);
      end
    end
    @(posedge clk);
    #1;
    in_valid = 0; load_close = 0; prog_done = 0;
    chk(prot_on, ep, rq, "prot_on");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tst_init = 1; in_valid = 0; in_addr = '0; in_data = '0;
    out_ready = 1; load_close = 0; prog_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; tst_init = 0;
    #1;
    chk(prot_on, 1'b0, 1, "reset prot_on");     // R1
    chk(out_valid, 1'b0, 1, "reset out_valid");
    chk(dummy_req, 1'b0, 1, "reset dummy_req");

    for (int i = 0; i < NV; i++)
      step(VEC[i].k, VEC[i].a, VEC[i].d, VEC[i].eo, VEC[i].ed, 1'b1, VEC[i].ep,
           int'(VEC[i].rq));

    // R7: reset keeps protection, test init clears it
    step(0, 17'h05555, 8'hAA, 0, 0, 1, 0, 7);
    step(0, 17'h02AAA, 8'h55, 0, 0, 1, 0, 7);
    step(0, 17'h05555, 8'hA0, 0, 1, 1, 0, 7);
    step(2, 17'h0, 8'h0, 0, 0, 1, 1, 7);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    chk(prot_on, 1'b1, 7, "prot_on after rst_n");
    @(negedge clk); tst_init = 1;
    @(negedge clk); tst_init = 0; #1;
    chk(prot_on, 1'b0, 7, "prot_on after tst_init");

    // R8: back-pressure and stalled writes
    out_ready = 0;
    step(0, 17'h00100, 8'h5A, 1, 0, 0, 0, 8);
    step(0, 17'h05555, 8'hAA, 0, 0, 1, 0, 8);   // command taken despite stall
    step(0, 17'h00101, 8'h5B, 1, 0, 0, 0, 8);   // offered, not accepted
    step(0, 17'h02AAA, 8'h55, 0, 0, 1, 0, 8);
    step(0, 17'h05555, 8'hA0, 0, 1, 1, 0, 8);   // sequence survived the stall
    out_ready = 1;
    step(2, 17'h0, 8'h0, 0, 0, 1, 1, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule